// File: doc/BRIEF.md
# Stop-Mode Power Controller with Wake Arbitration

This block guards a processor core's entry into a clock-stopped low-power state and decides how the core resumes. Software must first open a two-step key register with two writes. Only then does setting the stop bit in the standby control register halt the oscillator and core clock enables. The key is consumed in the same cycle. While stopped, external interrupt pins are sensed as active-low levels, and an externally clocked 8-bit timer keeps receiving count ticks, forced to falling edges.

A wake source ends the stop state. The possible sources are the reset pin, a non-maskable request, or a maskable source whose request and enable are both set. On wake the block raises a one-cycle wake pulse and presents a resume action code. The core uses that code to run reset processing, service the NMI, service the maskable source, or continue at the instruction after the one that stopped it. The action also depends on the master enable and on the interrupt context captured at the moment stop was entered. All pins are assumed synchronous to `clk`.

Top module: `stop_pwr_ctl`

## Requirements
- R1: A write to the key register (wr_sel=0) whose low nibble is 5h, followed directly by a key write whose low nibble is Ah, opens the key. The upper nibbles are ignored.
- R2: Any other key write leaves the key closed and returns it to its first step. A write with low nibble 5h always restarts at the second-step wait. With the key closed, a stop request is ignored.
- R3: A control write (wr_sel=1) with bit 0 set while the key is open enters stop from the next cycle: stp_bit=1, osc_en=0, core_clk_en=0. The key is closed in that same cycle, so a later stop request without a new key is ignored.
- R4: A control write with bit 0 set while the key is closed has no effect: stp_bit stays 0 and both clock enables stay 1.
- R5: nmi=1 while stopped (reset pin high) wakes the block on the next edge with resume_act=01 (service NMI), whatever the maskable inputs are.
- R6: A maskable source wakes the block only if the same index has irq_req=1 and irq_en=1. A request without its enable leaves the block stopped.
- R7: A maskable wake gives resume_act=10 (service maskable) when mie=1, and resume_act=00 (next instruction) when mie=0.
- R8: If ctx_nmi=1, or prio_mode=1 together with ctx_hi=1, at the stop-entry write, a maskable wake gives resume_act=00 even when mie=1. ctx_hi without prio_mode does not do this.
- R9: rst_pin_n=0 while stopped wakes with resume_act=11 (reset) and restarts the clocks, and it takes priority over nmi. rst_pin_n=0 while running closes the key.
- R10: ext_int_det[i] is a one-cycle pulse on the edge chosen by ext_edge_rise[i] (1 rising, 0 falling) while running. While stopped it is 1 in every cycle that follows a cycle with ext_int_n[i] low.
- R11: With tmr_ext_mode=1, tmr_tick pulses for one cycle on the edge of tmr_clk_pin chosen by tmr_edge_rise while running, and on falling edges only while stopped. With tmr_ext_mode=0 it stays 0.
- R12: wake_pulse is high for exactly one cycle when stop is left, and stp_bit returns to 0 then. Under rst: osc_en=1, core_clk_en=1, stp_bit=0, wake_pulse=0, resume_act=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high block reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 key register, 1 standby control |
| wr_data | input | DW | Write data |
| rst_pin_n | input | 1 | Reset pin, active low |
| nmi | input | 1 | Non-maskable request |
| irq_req | input | NSRC | Maskable request flags |
| irq_en | input | NSRC | Maskable enable flags |
| mie | input | 1 | Master interrupt enable |
| prio_mode | input | 1 | Interrupt priority mode on |
| ctx_nmi | input | 1 | Core is inside an NMI routine |
| ctx_hi | input | 1 | Core is inside a high-priority routine |
| ext_int_n | input | NEXTI | External interrupt pins |
| ext_edge_rise | input | NEXTI | Run-mode edge select per pin (1 rising) |
| tmr_clk_pin | input | 1 | External timer clock pin |
| tmr_ext_mode | input | 1 | Timer uses the external clock |
| tmr_edge_rise | input | 1 | Timer run-mode edge select (1 rising) |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| stp_bit | output | 1 | Readback of the stop bit |
| wake_pulse | output | 1 | One-cycle pulse on leaving stop |
| resume_act | output | 2 | 00 next instr, 01 NMI, 10 maskable, 11 reset |
| ext_int_det | output | NEXTI | External interrupt detect |
| tmr_tick | output | 1 | Timer count tick |

## Verification
The hardest case to reach from the ports is a maskable wake that must resolve to "next instruction" because of a locked context. The context exists only at the instant of the stop-entry write. The request that wakes the block arrives later, when the context inputs no longer matter. The table-driven stimulus therefore sets ctx_nmi, ctx_hi and prio_mode just before the control write. It raises the request and enable pair only after the clocks are seen off. Each row re-opens the key with different upper nibbles, and the directed tests mix the reset pin with nmi and switch the edge modes inside and outside stop.

// File: rtl/stpc_pkg.sv
package stpc_pkg;
  typedef enum logic [1:0] {
    ACT_NEXT  = 2'd0,
    ACT_NMI   = 2'd1,
    ACT_MASK  = 2'd2,
    ACT_RESET = 2'd3
  } resume_e;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_e;

  localparam logic SEL_KEY = 1'b0;
  localparam logic SEL_CTL = 1'b1;
endpackage

// File: rtl/stpc_unlock.sv
module stpc_unlock
  import stpc_pkg::*;
#(
  parameter int KW = 4,
  parameter logic [KW-1:0] KEY_A = 4'h5,
  parameter logic [KW-1:0] KEY_B = 4'hA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [KW-1:0] nib,
  input  logic          clr,
  output logic          armed
);
  key_e st, st_n;

  always_comb begin
    st_n = st;
    if (clr) begin
      st_n = KEY_IDLE;
    end else if (wr) begin
      if (nib == KEY_A) begin
        st_n = KEY_HALF;
      end else if (nib == KEY_B && st == KEY_HALF) begin
        st_n = KEY_OPEN;
      end else begin
        st_n = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= KEY_IDLE;
    else     st <= st_n;
  end

  assign armed = (st == KEY_OPEN);

  // R1
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr && st == KEY_HALF && nib == KEY_B) |=> armed);

  // R2
  key_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && st != KEY_HALF) |=> !armed);
endmodule

// File: rtl/stpc_wake.sv
module stpc_wake
  import stpc_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            stopped,
  input  logic            pin_rst_n,
  input  logic            nmi,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            mie,
  input  logic            lock,
  output logic            wake_now,
  output resume_e         act
);
  logic hit;

  always_comb begin
    hit      = |(req & en);
    wake_now = stopped & (~pin_rst_n | nmi | hit);
    if (!pin_rst_n)         act = ACT_RESET;
    else if (nmi)           act = ACT_NMI;
    else if (mie && !lock)  act = ACT_MASK;
    else                    act = ACT_NEXT;
  end
endmodule

// File: rtl/stpc_edge.sv
module stpc_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic en,
  input  logic rise_sel,
  input  logic level_mode,
  output logic det
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= pin;
      det  <= 1'b0;
    end else begin
      prev <= pin;
      if (!en)             det <= 1'b0;
      else if (level_mode) det <= ~pin;
      else if (rise_sel)   det <= pin & ~prev;
      else                 det <= ~pin & prev;
    end
  end

  // R10
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    (det && !level_mode && !$past(level_mode) && $stable(rise_sel)) |=> !det);
endmodule

// File: rtl/stop_pwr_ctl.sv
module stop_pwr_ctl
  import stpc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int KW    = 4,
  parameter int NSRC  = 4,
  parameter int NEXTI = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             rst_pin_n,
  input  logic             nmi,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             mie,
  input  logic             prio_mode,
  input  logic             ctx_nmi,
  input  logic             ctx_hi,
  input  logic [NEXTI-1:0] ext_int_n,
  input  logic [NEXTI-1:0] ext_edge_rise,
  input  logic             tmr_clk_pin,
  input  logic             tmr_ext_mode,
  input  logic             tmr_edge_rise,
  output logic             osc_en,
  output logic             core_clk_en,
  output logic             stp_bit,
  output logic             wake_pulse,
  output logic [1:0]       resume_act,
  output logic [NEXTI-1:0] ext_int_det,
  output logic             tmr_tick
);
  logic    key_wr, ctl_wr, armed, enter, key_clr, wake_now, stop_nxt;
  logic    stop_q, lock_q, osc_q, core_q, wake_q;
  resume_e act_q, act_nxt;
  logic    unused_bits;

  assign unused_bits = ^wr_data[DW-1:KW];

  assign key_wr  = wr_en && (wr_sel == SEL_KEY);
  assign ctl_wr  = wr_en && (wr_sel == SEL_CTL);
  assign enter   = ctl_wr && wr_data[0] && armed && !stop_q && rst_pin_n;
  assign key_clr = enter || !rst_pin_n;

  stpc_unlock #(.KW(KW)) u_key (
    .clk(clk), .rst(rst), .wr(key_wr), .nib(wr_data[KW-1:0]),
    .clr(key_clr), .armed(armed)
  );

  stpc_wake #(.NSRC(NSRC)) u_wake (
    .stopped(stop_q), .pin_rst_n(rst_pin_n), .nmi(nmi), .req(irq_req),
    .en(irq_en), .mie(mie), .lock(lock_q), .wake_now(wake_now), .act(act_nxt)
  );

  assign stop_nxt = stop_q ? !wake_now : enter;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      lock_q <= 1'b0;
      osc_q  <= 1'b1;
      core_q <= 1'b1;
      wake_q <= 1'b0;
      act_q  <= ACT_NEXT;
    end else begin
      stop_q <= stop_nxt;
      osc_q  <= !stop_nxt;
      core_q <= !stop_nxt;
      wake_q <= stop_q && wake_now;
      if (enter) lock_q <= ctx_nmi | (prio_mode & ctx_hi);
      if (stop_q && wake_now) act_q <= act_nxt;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NEXTI; gi++) begin : g_ext
      stpc_edge u_ext (
        .clk(clk), .rst(rst), .pin(ext_int_n[gi]), .en(1'b1),
        .rise_sel(ext_edge_rise[gi]), .level_mode(stop_q), .det(ext_int_det[gi])
      );
    end
  endgenerate

  stpc_edge u_tmr (
    .clk(clk), .rst(rst), .pin(tmr_clk_pin), .en(tmr_ext_mode),
    .rise_sel(tmr_edge_rise & ~stop_q), .level_mode(1'b0), .det(tmr_tick)
  );

  assign osc_en      = osc_q;
  assign core_clk_en = core_q;
  assign stp_bit     = stop_q;
  assign wake_pulse  = wake_q;
  assign resume_act  = act_q;

  // R3
  clk_off_chk: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> (!osc_q && !core_q));

  // R3
  key_used_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_q) |-> ($past(armed) && !armed));

  // R12
  wake_one_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);

  // R5
  nmi_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && rst_pin_n && nmi) |=> (wake_q && act_q == ACT_NMI && !stop_q));

  // R9
  pin_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !rst_pin_n) |=> (act_q == ACT_RESET && osc_q && !stop_q));

  // R6
  stay_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && rst_pin_n && !nmi && (irq_req & irq_en) == '0) |=> stop_q);

  // R8
  lock_next_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && rst_pin_n && !nmi && lock_q && (irq_req & irq_en) != '0)
      |=> act_q == ACT_NEXT);
endmodule

// File: tb/sim_stop_pwr_ctl.sv
module sim_stop_pwr_ctl;
  localparam int CLK_P = 10;
  localparam int NSRC  = 4;
  localparam int NEXTI = 4;

  typedef struct packed {
    logic       nmi;
    logic [3:0] req;
    logic [3:0] en;
    logic       mie;
    logic       prio;
    logic       cnmi;
    logic       chi;
    logic       prst;
    logic       wake;
    logic [1:0] act;
  } vec_t;

  localparam vec_t TBL [0:9] = '{
    '{1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1},
    '{1'b1, 4'h1, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1},
    '{1'b0, 4'h1, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
    '{1'b0, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    '{1'b0, 4'h2, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b0, 4'h8, 4'h8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},
    '{1'b0, 4'h4, 4'h4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    '{1'b0, 4'h4, 4'h4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
    '{1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3},
    '{1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_pin_n = 1'b1, nmi = 1'b0, mie = 1'b0, prio_mode = 1'b0;
  logic ctx_nmi = 1'b0, ctx_hi = 1'b0;
  logic [NSRC-1:0] irq_req = '0, irq_en = '0;
  logic [NEXTI-1:0] ext_int_n = '1, ext_edge_rise = '1;
  logic tmr_clk_pin = 1'b0, tmr_ext_mode = 1'b0, tmr_edge_rise = 1'b0;
  logic osc_en, core_clk_en, stp_bit, wake_pulse, tmr_tick;
  logic [1:0] resume_act;
  logic [NEXTI-1:0] ext_int_det;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  stop_pwr_ctl #(.NSRC(NSRC), .NEXTI(NEXTI)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rst_pin_n(rst_pin_n), .nmi(nmi), .irq_req(irq_req), .irq_en(irq_en),
    .mie(mie), .prio_mode(prio_mode), .ctx_nmi(ctx_nmi), .ctx_hi(ctx_hi),
    .ext_int_n(ext_int_n), .ext_edge_rise(ext_edge_rise),
    .tmr_clk_pin(tmr_clk_pin), .tmr_ext_mode(tmr_ext_mode),
    .tmr_edge_rise(tmr_edge_rise), .osc_en(osc_en), .core_clk_en(core_clk_en),
    .stp_bit(stp_bit), .wake_pulse(wake_pulse), .resume_act(resume_act),
    .ext_int_det(ext_int_det), .tmr_tick(tmr_tick)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic unlock(input logic [3:0] hi);
    wr(1'b0, {hi, 4'h5});
    wr(1'b0, {~hi, 4'hA});
  endtask

  task automatic wake_by_nmi();
    nmi = 1'b1;
    step();
    nmi = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_P * 50000);
    checks++; errors++;
    $display("FAIL R12 watchdog expired: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    // R12 reset state
    chk("R12 rst osc_en", osc_en, 1);
    chk("R12 rst core_clk_en", core_clk_en, 1);
    chk("R12 rst stp_bit", stp_bit, 0);
    chk("R12 rst wake", wake_pulse, 0);
    chk("R12 rst act", resume_act, 0);
    rst = 1'b0;
    step();

    for (int i = 0; i < 10; i++) begin
      mie = TBL[i].mie; prio_mode = TBL[i].prio;
      ctx_nmi = TBL[i].cnmi; ctx_hi = TBL[i].chi;
      unlock(4'(i));
      wr(1'b1, 8'h01);
      // R1 R3 entry after key
      chk("R3 stp_bit after entry", stp_bit, 1);
      chk("R3 osc_en off", osc_en, 0);
      chk("R3 core_clk_en off", core_clk_en, 0);
      ctx_nmi = 1'b0; ctx_hi = 1'b0; prio_mode = 1'b0;
      nmi = TBL[i].nmi; irq_req = TBL[i].req; irq_en = TBL[i].en;
      rst_pin_n = !TBL[i].prst;
      step();
      if (TBL[i].wake) begin
        // R5 R7 R8 R9 wake action
        chk($sformatf("R7 R8 R5 R9 act row %0d", i), resume_act, TBL[i].act);
        chk("R12 wake pulse high", wake_pulse, 1);
        chk("R12 stp_bit cleared", stp_bit, 0);
        chk("R9 osc_en back on", osc_en, 1);
        nmi = 1'b0; irq_req = '0; irq_en = '0; rst_pin_n = 1'b1;
        step();
        chk("R12 wake pulse one cycle", wake_pulse, 0);
      end else begin
        // R6 request without enable
        chk("R6 still stopped", stp_bit, 1);
        chk("R6 no wake pulse", wake_pulse, 0);
        irq_req = '0; irq_en = '0;
        wake_by_nmi();
      end
      mie = 1'b0;
    end

    // R4 stop without key
    wr(1'b1, 8'h01);
    chk("R4 stp_bit stays 0", stp_bit, 0);
    chk("R4 osc_en stays 1", osc_en, 1);

    // R3 key consumed: enter, wake, try again without key
    unlock(4'h0);
    wr(1'b1, 8'h01);
    wake_by_nmi();
    wr(1'b1, 8'h01);
    chk("R3 second stop ignored", stp_bit, 0);

    // R2 stray key write between codes
    wr(1'b0, 8'h05); wr(1'b0, 8'h33); wr(1'b0, 8'h0A);
    wr(1'b1, 8'h01);
    chk("R2 stray write drops key", stp_bit, 0);
    // R2 lone second code
    wr(1'b0, 8'h7A);
    wr(1'b1, 8'h01);
    chk("R2 lone Ah no key", stp_bit, 0);
    // R2 repeated 5h restarts, then Ah opens
    wr(1'b0, 8'h05); wr(1'b0, 8'hE5); wr(1'b0, 8'h1A);
    wr(1'b1, 8'h01);
    chk("R2 5h restart then open", stp_bit, 1);
    wake_by_nmi();

    // R9 reset pin while running closes key
    unlock(4'h3);
    rst_pin_n = 1'b0; step(); rst_pin_n = 1'b1;
    wr(1'b1, 8'h01);
    chk("R9 pin low drops key", stp_bit, 0);
    chk("R9 osc_en on", osc_en, 1);

    // R10 run-mode edges
    ext_int_n[0] = 1'b0; step();
    chk("R10 falling ignored on rising select", ext_int_det[0], 0);
    ext_int_n[0] = 1'b1; step();
    chk("R10 rising pulse", ext_int_det[0], 1);
    step();
    chk("R10 pulse one cycle", ext_int_det[0], 0);
    ext_edge_rise[1] = 1'b0; ext_int_n[1] = 1'b0; step();
    chk("R10 falling pulse", ext_int_det[1], 1);
    ext_int_n[1] = 1'b1; step();
    chk("R10 rising ignored on falling select", ext_int_det[1], 0);

    // R10 R11 in stop
    tmr_ext_mode = 1'b1; tmr_edge_rise = 1'b1;
    unlock(4'h9);
    wr(1'b1, 8'h01);
    ext_int_n[0] = 1'b0; step();
    chk("R10 stop level 1", ext_int_det[0], 1);
    step();
    chk("R10 stop level held", ext_int_det[0], 1);
    ext_int_n[0] = 1'b1; step();
    chk("R10 stop level released", ext_int_det[0], 0);
    tmr_clk_pin = 1'b1; step();
    chk("R11 stop rising ignored", tmr_tick, 0);
    tmr_clk_pin = 1'b0; step();
    chk("R11 stop falling tick", tmr_tick, 1);
    chk("R11 still stopped", stp_bit, 1);
    wake_by_nmi();
    tmr_clk_pin = 1'b1; step();
    chk("R11 run rising tick", tmr_tick, 1);
    tmr_clk_pin = 1'b0; step();
    chk("R11 run falling ignored", tmr_tick, 0);
    tmr_ext_mode = 1'b0;
    tmr_clk_pin = 1'b1; step();
    chk("R11 internal mode no tick", tmr_tick, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule